// File: doc/BRIEF.md
# NOR flash command sequencer

This block runs program and erase operations on a 32-bit flash bus built from two 16-bit command-set flash devices placed side by side. Each command byte goes out on both 16-bit lanes at once, so both devices take it in the same bus write. A host hands over one request at a time through a valid/ready handshake. A request is either a single-word program or a single-block erase. The sequencer then issues the command writes and polls the status word until both lanes report ready. It writes the read-array command and reports the result as a one-cycle done pulse with a pass flag and a timeout flag.

A program operation is also checked by reading the word back in read-array mode after the status polling ends. Any difference from the written data fails the operation, even when the status error bits are clear. A programmable poll limit stops a device that never becomes ready. When the limit is reached the sequencer still returns the device to read-array mode before it reports a timeout.

The flash side is a simple synchronous bus. It has an address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data qualified by a read-valid input that may come back any number of cycles later. While a read is outstanding, no other strobe is issued.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset reqReady is 1, doneValid is 0 and neither bus strobe is active. reqReady is 1 only while the sequencer is idle, and a request is taken on a cycle with reqValid and reqReady both high.
- R2: Each command write places the same 8-bit code in bits 7:0 and in bits 23:16, with all other bits zero. Read-array is therefore 0x00FF00FF.
- R3: An erase (reqErase=1) writes 0x00200020 and then 0x00D000D0, both to the request address.
- R4: A program (reqErase=0) writes 0x00400040 to the request address, then writes reqData to the same address.
- R5: After those two writes the sequencer repeats two steps: it writes 0x00700070, then reads one word. It stops when both ready bits in mask 0x00800080 are set. A status with only one lane ready keeps it polling.
- R6: When polling ends, for either a ready status or a timeout, the sequencer writes 0x00FF00FF before it raises doneValid.
- R7: An erase reports donePass=0 if the final status has any bit of mask 0x00200020 set, on either lane.
- R8: A program reports donePass=0 if the final status has any bit of mask 0x00100010 set, on either lane.
- R9: A program that did not time out reads its address once after the read-array write. If that word differs from reqData, it reports donePass=0.
- R10: If pollLimit consecutive status reads all show not-ready, the operation ends with doneTimeout=1 and donePass=0. A pollLimit of 0 acts as 1. A timed-out operation does no read-back.
- R11: A program whose address has bits 1:0 not both zero completes with donePass=0 and doneTimeout=0, without any bus write or read.
- R12: doneValid lasts exactly one cycle. fWr and fRd are never high together, and neither is raised while a read is waiting for fRvalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle; request accepted when both high |
| reqErase | input | 1 | 1 = block erase, 0 = word program |
| reqAddr | input | ADDR_W | Byte address of the word or inside the block |
| reqData | input | 32 | Word to program |
| pollLimit | input | CNT_W | Maximum number of status reads that show busy |
| doneValid | output | 1 | One-cycle completion pulse |
| donePass | output | 1 | Operation succeeded (valid with doneValid) |
| doneTimeout | output | 1 | Poll limit reached (valid with doneValid) |
| fAddr | output | ADDR_W | Flash bus address |
| fWdata | output | 32 | Flash bus write data |
| fRdata | input | 32 | Flash bus read data |
| fWr | output | 1 | One-cycle write strobe |
| fRd | output | 1 | One-cycle read strobe |
| fRvalid | input | 1 | Read data valid |

## Verification
The assertions watch rules that hold on every cycle without knowing which operation is running. These are the idle-only ready, the one-cycle done pulse, strobe exclusion, the absence of strobes while a read is pending, the read-array write as the last write before done, and a timeout never reporting a pass. Everything that depends on the device's answers can only be shown by the bench scenarios. That covers the exact command order and addresses, the number of poll rounds, per-lane ready and error decoding, the read-back mismatch, the timeout count including a limit of zero, and the silent rejection of an unaligned program. The bench runs these against a behavioural device with a settable busy time, a settable busy pattern, injected error bits and injected corruption.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int LANE_W = 16;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  localparam logic [7:0] CODE_ARRAY   = 8'hFF;
  localparam logic [7:0] CODE_STATUS  = 8'h70;
  localparam logic [7:0] CODE_ERASE   = 8'h20;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_PROG    = 8'h40;

  // Replicate an 8-bit pattern into the low byte of every lane.
  function automatic logic [DATA_W-1:0] laneDup(input logic [7:0] code);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: 8] = code;
    return r;
  endfunction

  localparam logic [DATA_W-1:0] MASK_READY    = laneDup(8'h80);
  localparam logic [DATA_W-1:0] MASK_ERASEERR = laneDup(8'h20);
  localparam logic [DATA_W-1:0] MASK_PROGERR  = laneDup(8'h10);

  typedef enum logic [1:0] {W_SETUP, W_SECOND, W_STATUS, W_ARRAY} wsel_e;

  typedef struct packed {
    logic  latch;
    logic  wr;
    wsel_e wsel;
    logic  rd;
    logic  capStat;
    logic  capVer;
    logic  cntInc;
    logic  markTimeout;
    logic  markMisalign;
  } dp_strobe_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqMisaligned,
  input  logic       opErase,
  input  logic       tmoFlag,
  input  logic       statReady,
  input  logic       limitHit,
  input  logic       fRvalid,
  output logic       reqReady,
  output logic       doneValid,
  output dp_strobe_t st
);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_SECOND, S_POLLW, S_POLLR, S_STWAIT,
    S_ARRAY, S_VRD, S_VWAIT, S_REPORT
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt       = state;
    st        = '0;
    st.wsel   = W_SETUP;
    reqReady  = 1'b0;
    doneValid = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          st.latch = 1'b1;
          if (reqMisaligned) begin
            st.markMisalign = 1'b1;
            nxt = S_REPORT;
          end else begin
            nxt = S_SETUP;
          end
        end
      end
      S_SETUP: begin
        st.wr   = 1'b1;
        st.wsel = W_SETUP;
        nxt     = S_SECOND;
      end
      S_SECOND: begin
        st.wr   = 1'b1;
        st.wsel = W_SECOND;
        nxt     = S_POLLW;
      end
      S_POLLW: begin
        st.wr   = 1'b1;
        st.wsel = W_STATUS;
        nxt     = S_POLLR;
      end
      S_POLLR: begin
        st.rd = 1'b1;
        nxt   = S_STWAIT;
      end
      S_STWAIT: begin
        if (fRvalid) begin
          st.capStat = 1'b1;
          if (statReady) begin
            nxt = S_ARRAY;
          end else if (limitHit) begin
            st.markTimeout = 1'b1;
            nxt = S_ARRAY;
          end else begin
            st.cntInc = 1'b1;
            nxt = S_POLLW;
          end
        end
      end
      S_ARRAY: begin
        st.wr   = 1'b1;
        st.wsel = W_ARRAY;
        nxt     = (!opErase && !tmoFlag) ? S_VRD : S_REPORT;
      end
      S_VRD: begin
        st.rd = 1'b1;
        nxt   = S_VWAIT;
      end
      S_VWAIT: begin
        if (fRvalid) begin
          st.capVer = 1'b1;
          nxt = S_REPORT;
        end
      end
      S_REPORT: begin
        doneValid = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        st,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [CNT_W-1:0]  pollLimit,
  input  logic [DATA_W-1:0] fRdata,
  output logic              reqMisaligned,
  output logic              opErase,
  output logic              tmoFlag,
  output logic              statReady,
  output logic              limitHit,
  output logic              donePass,
  output logic              doneTimeout,
  output logic [ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0] fWdata,
  output logic              fWr,
  output logic              fRd
);

  localparam int WORD_LSB = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;
  logic [CNT_W-1:0]  pollCnt;
  logic [CNT_W:0]    nextCnt;
  logic              errFlag, misFlag, cmpFlag;

  assign reqMisaligned = !reqErase && (|reqAddr[WORD_LSB-1:0]);
  assign statReady     = (fRdata & MASK_READY) == MASK_READY;
  assign nextCnt       = {1'b0, pollCnt} + (CNT_W+1)'(1);
  assign limitHit      = nextCnt >= {1'b0, pollLimit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr  <= '0;
      opData  <= '0;
      opErase <= 1'b0;
      pollCnt <= '0;
      errFlag <= 1'b0;
      misFlag <= 1'b0;
      cmpFlag <= 1'b0;
      tmoFlag <= 1'b0;
    end else begin
      if (st.latch) begin
        opAddr  <= reqAddr;
        opData  <= reqData;
        opErase <= reqErase;
        pollCnt <= '0;
        errFlag <= 1'b0;
        misFlag <= 1'b0;
        cmpFlag <= 1'b0;
        tmoFlag <= 1'b0;
      end
      if (st.markMisalign) misFlag <= 1'b1;
      if (st.cntInc)       pollCnt <= pollCnt + 1'b1;
      if (st.markTimeout)  tmoFlag <= 1'b1;
      if (st.capStat)
        errFlag <= |(fRdata & (opErase ? MASK_ERASEERR : MASK_PROGERR));
      if (st.capVer)
        cmpFlag <= fRdata != opData;
    end
  end

  always_comb begin
    case (st.wsel)
      W_SETUP:  fWdata = laneDup(opErase ? CODE_ERASE : CODE_PROG);
      W_SECOND: fWdata = opErase ? laneDup(CODE_CONFIRM) : opData;
      W_STATUS: fWdata = laneDup(CODE_STATUS);
      default:  fWdata = laneDup(CODE_ARRAY);
    endcase
  end

  assign fAddr       = opAddr;
  assign fWr         = st.wr;
  assign fRd         = st.rd;
  assign donePass    = !(errFlag || misFlag || cmpFlag || tmoFlag);
  assign doneTimeout = tmoFlag;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [CNT_W-1:0]  pollLimit,
  output logic              doneValid,
  output logic              donePass,
  output logic              doneTimeout,
  output logic [ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0] fWdata,
  input  logic [DATA_W-1:0] fRdata,
  output logic              fWr,
  output logic              fRd,
  input  logic              fRvalid
);

  dp_strobe_t st;
  logic reqMisaligned, opErase, tmoFlag, statReady, limitHit;

  flash_seq_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqMisaligned (reqMisaligned),
    .opErase       (opErase),
    .tmoFlag       (tmoFlag),
    .statReady     (statReady),
    .limitHit      (limitHit),
    .fRvalid       (fRvalid),
    .reqReady      (reqReady),
    .doneValid     (doneValid),
    .st            (st)
  );

  flash_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .st            (st),
    .reqErase      (reqErase),
    .reqAddr       (reqAddr),
    .reqData       (reqData),
    .pollLimit     (pollLimit),
    .fRdata        (fRdata),
    .reqMisaligned (reqMisaligned),
    .opErase       (opErase),
    .tmoFlag       (tmoFlag),
    .statReady     (statReady),
    .limitHit      (limitHit),
    .donePass      (donePass),
    .doneTimeout   (doneTimeout),
    .fAddr         (fAddr),
    .fWdata        (fWdata),
    .fWr           (fWr),
    .fRd           (fRd)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              doneValid,
  input logic              donePass,
  input logic              doneTimeout,
  input logic [DATA_W-1:0] fWdata,
  input logic              fWr,
  input logic              fRd,
  input logic              fRvalid
);

  logic readPending, wroteAny, lastArray;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readPending <= 1'b0;
      wroteAny    <= 1'b0;
      lastArray   <= 1'b0;
    end else begin
      if (fRd) readPending <= 1'b1;
      else if (fRvalid) readPending <= 1'b0;
      if (doneValid) wroteAny <= 1'b0;
      else if (fWr) wroteAny <= 1'b1;
      if (fWr) lastArray <= fWdata == laneDup(CODE_ARRAY);
    end
  end

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!fWr && !fRd && !doneValid)); // R1
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R1
  AST_ARRAY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && wroteAny) |-> lastArray); // R6
  AST_TIMEOUT_NO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneTimeout) |-> !donePass); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R12
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fWr && fRd)); // R12
  AST_QUIET_WHILE_READ: assert property (@(posedge clk) disable iff (!rstN)
    readPending |-> (!fWr && !fRd)); // R12

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .doneValid   (doneValid),
  .donePass    (donePass),
  .doneTimeout (doneTimeout),
  .fWdata      (fWdata),
  .fWr         (fWr),
  .fRd         (fRd),
  .fRvalid     (fRvalid)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;

  localparam int AW = 24;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqErase = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqData = '0;
  logic [CW-1:0] pollLimit = '0;
  logic          doneValid, donePass, doneTimeout;
  logic [AW-1:0] fAddr;
  logic [31:0]   fWdata;
  logic [31:0]   fRdata;
  logic          fWr, fRd;
  logic          fRvalid;

  always #2 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .CNT_W(CW)) u_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqErase(reqErase), .reqAddr(reqAddr), .reqData(reqData),
    .pollLimit(pollLimit), .doneValid(doneValid), .donePass(donePass),
    .doneTimeout(doneTimeout), .fAddr(fAddr), .fWdata(fWdata),
    .fRdata(fRdata), .fWr(fWr), .fRd(fRd), .fRvalid(fRvalid)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural device
  int          busyCfg = 0;
  logic [31:0] busyPat = 32'h0;
  logic [31:0] errInj  = 32'h0;
  bit          corrupt = 1'b0;
  int          busyLeft;
  bit          statusMode, expectData;
  logic [31:0] mem [0:15];
  logic        rvPipe;
  logic [31:0] rdPipe;

  always @(posedge clk) begin
    if (!rstN) begin
      busyLeft <= 0; statusMode <= 1'b0; expectData <= 1'b0;
      rvPipe <= 1'b0; rdPipe <= '0; fRvalid <= 1'b0; fRdata <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'hFFFF_FFFF;
    end else begin
      rvPipe  <= fRd;
      fRvalid <= rvPipe;
      fRdata  <= rdPipe;
      if (fRd) begin
        if (statusMode) begin
          if (busyLeft > 0) begin
            rdPipe   <= busyPat;
            busyLeft <= busyLeft - 1;
          end else begin
            rdPipe <= 32'h0080_0080 | errInj;
          end
        end else begin
          rdPipe <= mem[fAddr[5:2]];
        end
      end
      if (fWr) begin
        if (expectData) begin
          mem[fAddr[5:2]] <= corrupt ? (fWdata ^ 32'h1) : fWdata;
          expectData <= 1'b0;
          busyLeft   <= busyCfg;
          statusMode <= 1'b1;
        end else begin
          case (fWdata)
            32'h0040_0040: expectData <= 1'b1;
            32'h00D0_00D0: begin busyLeft <= busyCfg; statusMode <= 1'b1; end
            32'h0070_0070: statusMode <= 1'b1;
            32'h00FF_00FF: statusMode <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  // reference bus sequence, compared every clock
  logic [55:0] expW[$];
  string       expTag[$];
  int          rdCount = 0;
  bit          pend = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (fWr || fRd)
        chk(!(fWr && fRd) && !pend, "R12", "strobe overlap or issued while read pending",
            {62'd0, fWr, fRd}, {63'd0, 1'b1});
      if (fWr) begin
        if (expW.size() == 0) begin
          chk(1'b0, "R11", "unexpected bus write", {8'd0, fAddr, fWdata}, 64'd0);
        end else begin
          logic [55:0] e;
          string t;
          e = expW.pop_front();
          t = expTag.pop_front();
          chk({fAddr, fWdata} == e, t, "bus write", {8'd0, fAddr, fWdata}, {8'd0, e});
        end
      end
      if (fRd) begin rdCount++; pend = 1'b1; end
      else if (fRvalid) pend = 1'b0;
    end
  end

  task automatic pushW(input logic [AW-1:0] a, input logic [31:0] d, input string t);
    expW.push_back({a, d});
    expTag.push_back(t);
  endtask

  task automatic runOp(input bit erase, input logic [AW-1:0] addr, input logic [31:0] data,
                       input int busy, input logic [31:0] pat, input logic [31:0] err,
                       input bit corr, input int limit, input string tag);
    bit mis, tmo, pass;
    int effL, k, expRd, waitCnt;
    mis  = !erase && (addr[1:0] != 2'b00);
    effL = (limit < 1) ? 1 : limit;
    tmo  = 1'b0;
    k    = 0;
    if (!mis) begin
      if (busy >= effL) begin k = effL; tmo = 1'b1; end
      else k = busy + 1;
    end
    expRd = k + ((!erase && !tmo && !mis) ? 1 : 0);
    pass  = !mis && !tmo && ((err & (erase ? 32'h0020_0020 : 32'h0010_0010)) == 0)
            && (erase || !corr);
    @(negedge clk);
    if (!mis) begin
      pushW(addr, erase ? 32'h0020_0020 : 32'h0040_0040, erase ? "R3" : "R4");
      pushW(addr, erase ? 32'h00D0_00D0 : data, erase ? "R3" : "R4");
      for (int i = 0; i < k; i++) pushW(addr, 32'h0070_0070, "R5");
      pushW(addr, 32'h00FF_00FF, "R6");
    end
    busyCfg = busy; busyPat = pat; errInj = err; corrupt = corr;
    pollLimit = CW'(limit);
    rdCount = 0;
    chk(reqReady == 1'b1, "R1", {tag, " ready before request"}, {63'd0, reqReady}, 64'd1);
    reqValid = 1'b1; reqErase = erase; reqAddr = addr; reqData = data;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    waitCnt = 0;
    while (!doneValid && waitCnt < 5000) begin
      if (reqReady) chk(1'b0, "R1", {tag, " ready while busy"}, 64'd1, 64'd0);
      @(negedge clk);
      waitCnt++;
    end
    chk(doneValid == 1'b1, "R12", {tag, " done seen"}, {63'd0, doneValid}, 64'd1);
    chk(donePass == pass, tag, "donePass", {63'd0, donePass}, {63'd0, pass});
    chk(doneTimeout == tmo, tag, "doneTimeout", {63'd0, doneTimeout}, {63'd0, tmo});
    chk(expW.size() == 0, "R6", {tag, " writes missing before done"}, 64'(expW.size()), 64'd0);
    chk(rdCount == expRd, tag, "bus read count", 64'(rdCount), 64'(expRd));
    expW.delete(); expTag.delete();
    @(negedge clk);
    chk(doneValid == 1'b0, "R12", {tag, " done lasts one cycle"}, {63'd0, doneValid}, 64'd0);
    chk(reqReady == 1'b1, "R1", {tag, " idle after done"}, {63'd0, reqReady}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reset reqReady", {63'd0, reqReady}, 64'd1);
    chk(doneValid == 1'b0, "R1", "reset doneValid", {63'd0, doneValid}, 64'd0);
    chk(!fWr && !fRd, "R1", "reset strobes", {62'd0, fWr, fRd}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R9: program passes after a few busy polls, then verified
    runOp(1'b0, 24'h000010, 32'hA5C3_1E07, 3, 32'h0, 32'h0, 1'b0, 10, "R4");
    // R3 R2: erase at an address inside the block
    runOp(1'b1, 24'h008006, 32'h0, 2, 32'h0, 32'h0, 1'b0, 10, "R3");
    // R5: only low lane ready while busy keeps polling
    runOp(1'b0, 24'h000020, 32'h0123_4567, 4, 32'h0000_0080, 32'h0, 1'b0, 10, "R5");
    // R5: ready at once, single poll round
    runOp(1'b1, 24'h010000, 32'h0, 0, 32'h0, 32'h0, 1'b0, 10, "R5");
    // R7: erase error on upper lane only
    runOp(1'b1, 24'h018000, 32'h0, 1, 32'h0, 32'h0020_0000, 1'b0, 10, "R7");
    // R8: program error on lower lane only
    runOp(1'b0, 24'h000030, 32'h5555_AAAA, 1, 32'h0, 32'h0000_0010, 1'b0, 10, "R8");
    // R9: read-back mismatch with clean status
    runOp(1'b0, 24'h000034, 32'hDEAD_BEEF, 2, 32'h0, 32'h0, 1'b1, 10, "R9");
    // R10: program never ready within 5 reads
    runOp(1'b0, 24'h000038, 32'h1111_2222, 20, 32'h0080_0000, 32'h0, 1'b0, 5, "R10");
    // R10: limit zero acts as one
    runOp(1'b1, 24'h020000, 32'h0, 1, 32'h0, 32'h0, 1'b0, 0, "R10");
    // R10: ready on exactly the last allowed read does not time out
    runOp(1'b0, 24'h00003C, 32'h7E7E_8181, 3, 32'h0, 32'h0, 1'b0, 4, "R10");
    // R11: unaligned program, no bus traffic
    runOp(1'b0, 24'h000042, 32'hCAFE_F00D, 1, 32'h0, 32'h0, 1'b0, 10, "R11");
    // R2 R6: program data equal to a command pattern still ends correctly
    runOp(1'b0, 24'h000004, 32'h00FF_00FF, 2, 32'h0, 32'h0, 1'b0, 10, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule